// File: doc/BRIEF.md
# Age-Matrix LRU Victim Selector

This block keeps recency order for a 4-way set-associative cache with 32 sets. It does not hold data or tags. Each set has a pairwise age matrix. Bit [i][j] is 1 when way i was used more recently than way j. On every hit or fill, the cache raises `acc_valid` with the set and the way it touched. That way then becomes the newest in its set.

The way to evict next is kept ready for every set. It is recomputed in the same cycle that the set's matrix is written. A miss therefore only needs a single table read. `victim_way` is registered, so it shows the replacement way for the set that was on `set_idx` in the previous cycle. If that previous cycle also carried an access to the same set, the value already includes that access.

After reset, every set holds the order way 0 oldest, then way 1, then way 2, with way 3 newest.

Top module: `lru_age_victim`

## Requirements
- R1: While reset is held and after it is released, `victim_way` is 0, and a lookup of any set with no prior access returns way 0.
- R2: The reset order of every set is way 0 oldest, then 1, then 2, then 3. Touching ways 0, 1, 2 and 3 in turn gives the victims 1, 2, 3 and 0.
- R3: A way that has just been accessed is never the victim of its set on the next cycle.
- R4: The victim of a set is always the least recently accessed of its four ways, counting the reset order as the oldest history.
- R5: An access to a way that is not the current victim leaves the victim of that set unchanged.
- R6: An access to one set does not change the victim of any other set.
- R7: `victim_way` is a register. It shows the victim of the set presented on `set_idx` exactly one clock earlier, and it can follow a different set every cycle.
- R8: When an access and a lookup hit the same set in the same cycle, the result is the victim after that access.
- R9: With `acc_valid` low, the value on `acc_way` has no effect, and repeated lookups of a set return the same victim.
- R10: Repeated accesses to the same way leave the order of the other ways unchanged, so the victim stays the same.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | High when the cache hit or filled `acc_way` in set `set_idx` this cycle |
| set_idx | input | 5 | Set being looked up, and updated when `acc_valid` is high |
| acc_way | input | 2 | Way that was accessed; used only when `acc_valid` is high |
| victim_way | output | 2 | Registered replacement way for the set presented one cycle earlier |

## Verification
Every result of this block is due exactly one rising edge after its stimulus. Inputs applied on a falling edge appear on `victim_way` after the next rising edge, and this includes an access folded into the same-cycle lookup. The driver places one expected victim in a queue for each cycle it drives. The expected value comes from a per-way time-stamp model that is independent of the matrix. The monitor takes one queue entry just after each following rising edge, so every comparison is aligned to the single register stage.

// File: rtl/lru_age_pkg.sv
package lru_age_pkg;
    parameter int unsigned LRU_WAYS_DEF = 4;
    parameter int unsigned LRU_SETS_DEF = 32;

    function automatic int unsigned idx_bits(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/lru_age_update.sv
module lru_age_update #(
    parameter int unsigned WAYS = lru_age_pkg::LRU_WAYS_DEF,
    localparam int unsigned VW  = lru_age_pkg::idx_bits(WAYS)
) (
    input  logic [WAYS-1:0][WAYS-1:0] cur_m,
    input  logic [VW-1:0]             way,
    output logic [WAYS-1:0][WAYS-1:0] nxt_m
);
    // Touched way: its row goes to ones (newer than all others),
    // its column goes to zeros (nobody is newer than it). Diagonal stays 0.
    for (genvar i = 0; i < WAYS; i++) begin : g_row
        for (genvar j = 0; j < WAYS; j++) begin : g_col
            if (i == j) begin : g_diag
                assign nxt_m[i][j] = 1'b0;
            end else begin : g_off
                assign nxt_m[i][j] = (int'(way) == i) ? 1'b1 :
                                     (int'(way) == j) ? 1'b0 : cur_m[i][j];
            end
        end
    end
endmodule

// File: rtl/lru_age_pick.sv
module lru_age_pick #(
    parameter int unsigned WAYS = lru_age_pkg::LRU_WAYS_DEF,
    localparam int unsigned VW  = lru_age_pkg::idx_bits(WAYS)
) (
    input  logic [WAYS-1:0][WAYS-1:0] m,
    output logic [VW-1:0]             victim
);
    logic [WAYS-1:0] oldest;

    // A way is oldest when no off-diagonal bit of its row is set.
    for (genvar i = 0; i < WAYS; i++) begin : g_zero
        logic [WAYS-1:0] diag_mask;
        assign diag_mask = ~(WAYS'(1) << i);
        assign oldest[i] = ~|(m[i] & diag_mask);
    end

    always_comb begin
        victim = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (oldest[i]) victim = VW'(i);
        end
    end
endmodule

// File: rtl/lru_age_victim.sv
module lru_age_victim #(
    parameter int unsigned WAYS = lru_age_pkg::LRU_WAYS_DEF,
    parameter int unsigned SETS = lru_age_pkg::LRU_SETS_DEF,
    localparam int unsigned VW  = lru_age_pkg::idx_bits(WAYS),
    localparam int unsigned SW  = lru_age_pkg::idx_bits(SETS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_valid,
    input  logic [SW-1:0] set_idx,
    input  logic [VW-1:0] acc_way,
    output logic [VW-1:0] victim_way
);
    typedef logic [WAYS-1:0][WAYS-1:0] mat_t;

    typedef struct packed {
        mat_t [SETS-1:0]          mat;
        logic [SETS-1:0][VW-1:0]  vic;
        logic [VW-1:0]            out;
    } st_t;

    function automatic st_t rst_state();
        st_t s;
        s = '0;
        for (int k = 0; k < SETS; k++) begin
            for (int i = 0; i < WAYS; i++) begin
                for (int j = 0; j < WAYS; j++) begin
                    if (i > j) s.mat[k][i][j] = 1'b1;
                end
            end
        end
        return s;
    endfunction

    st_t           st_d, st_q;
    mat_t          cur_m, nxt_m;
    logic [VW-1:0] nxt_vic;

    assign cur_m = st_q.mat[set_idx];

    lru_age_update #(.WAYS(WAYS)) u_update (
        .cur_m (cur_m),
        .way   (acc_way),
        .nxt_m (nxt_m)
    );

    lru_age_pick #(.WAYS(WAYS)) u_pick (
        .m      (nxt_m),
        .victim (nxt_vic)
    );

    always_comb begin
        st_d = st_q;
        if (acc_valid) begin
            st_d.mat[set_idx] = nxt_m;
            st_d.vic[set_idx] = nxt_vic;
            st_d.out          = nxt_vic;
        end else begin
            st_d.out          = st_q.vic[set_idx];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= rst_state();
        else        st_q <= st_d;
    end

    assign victim_way = st_q.out;

    // ---------------- assertions ----------------
    logic past_ok_q;
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok_q <= 1'b0;
        else        past_ok_q <= 1'b1;
    end

    AST_NOT_JUST_USED: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> victim_way != $past(acc_way)); // R3

    AST_VICTIM_ROW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |-> ((nxt_m[nxt_vic] & ~(WAYS'(1) << nxt_vic)) == '0)); // R4

    for (genvar i = 0; i < WAYS; i++) begin : g_ast_i
        for (genvar j = i + 1; j < WAYS; j++) begin : g_ast_j
            AST_ORDER_ANTISYM: assert property (@(posedge clk) disable iff (!rst_n)
                acc_valid |-> nxt_m[i][j] != nxt_m[j][i]); // R4
        end
    end

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok_q && !acc_valid && !$past(acc_valid) && set_idx == $past(set_idx))
        |=> $stable(victim_way)); // R9
endmodule

// File: tb/lru_age_victim_tb.sv
module lru_age_victim_tb;
    localparam int WAYS = 4;
    localparam int SETS = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_valid = 1'b0;
    logic [4:0] set_idx = '0;
    logic [1:0] acc_way = '0;
    logic [1:0] victim_way;

    always #5 clk = ~clk;

    lru_age_victim u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_valid  (acc_valid),
        .set_idx    (set_idx),
        .acc_way    (acc_way),
        .victim_way (victim_way)
    );

    typedef struct { int exp; string tag; } item_t;
    item_t q[$];

    int total = 0;
    int bad   = 0;
    int stamp [SETS][WAYS];
    int tick  = 100;

    task automatic check(input int got, input int exp, input string tag);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s got=%0d exp=%0d at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic int model_victim(input int s);
        int best = 0;
        for (int w = 1; w < WAYS; w++) if (stamp[s][w] < stamp[s][best]) best = w;
        return best;
    endfunction

    // Driver: applies one cycle of stimulus and queues the expected victim.
    task automatic drive(input int s, input bit v, input int w, input string tag);
        item_t it;
        @(negedge clk);
        set_idx   = 5'(s);
        acc_valid = v;
        acc_way   = 2'(w);
        if (v) begin
            stamp[s][w] = tick;
            tick++;
        end
        it.exp = model_victim(s);
        it.tag = tag;
        q.push_back(it);
    endtask

    // Monitor: result due one rising edge after the stimulus.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                check(int'(victim_way), it.exp, it.tag);
            end
        end
    end

    initial begin
        for (int c = 0; c < 200000; c++) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) stamp[s][w] = w;

        repeat (3) @(posedge clk);
        #1;
        check(int'(victim_way), 0, "R1 during reset");
        @(negedge clk);
        rst_n = 1'b1;

        // R1: every set starts with way 0 as victim
        for (int s = 0; s < SETS; s++) drive(s, 1'b0, 3, "R1 lookup");

        // R2: reset order 0,1,2,3
        drive(3, 1'b1, 0, "R2 touch0");
        drive(3, 1'b1, 1, "R2 touch1");
        drive(3, 1'b1, 2, "R2 touch2");
        drive(3, 1'b1, 3, "R2 touch3");

        // R5: non-victim access keeps victim
        drive(7, 1'b1, 2, "R5 keep");
        drive(7, 1'b1, 3, "R5 keep");
        drive(7, 1'b0, 0, "R5 lookup");

        // R6: neighbour sets untouched
        drive(5, 1'b1, 0, "R6 touch");
        drive(5, 1'b1, 1, "R6 touch");
        drive(6, 1'b0, 0, "R6 other");
        drive(4, 1'b0, 0, "R6 other");

        // R9: acc_way ignored while acc_valid low
        drive(9, 1'b0, 0, "R9 idle");
        drive(9, 1'b0, 1, "R9 idle");
        drive(9, 1'b0, 2, "R9 idle");

        // R10: repeat same way
        drive(10, 1'b1, 1, "R10 repeat");
        drive(10, 1'b1, 1, "R10 repeat");
        drive(10, 1'b1, 1, "R10 repeat");

        // R3 and R8: touch the victim, same-cycle lookup sees new victim
        drive(11, 1'b1, 0, "R8 same cycle");
        drive(11, 1'b1, 1, "R3 touched victim");

        // R7: lookups switching set every cycle
        drive(3, 1'b0, 0, "R7 alt");
        drive(5, 1'b0, 0, "R7 alt");
        drive(11, 1'b0, 0, "R7 alt");
        drive(3, 1'b0, 0, "R7 alt");

        // R4: mixed random traffic
        for (int n = 0; n < 3000; n++) begin
            drive(int'($urandom_range(0, SETS - 1)), 1'($urandom_range(0, 1)),
                  int'($urandom_range(0, WAYS - 1)), "R4 random");
        end

        @(negedge clk);
        acc_valid = 1'b0;
        repeat (3) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule